// File: doc/BRIEF.md
# Flash Write/Erase Controller

This block guards a word-addressed non-volatile array split into a main region of equal-size pages and a small user configuration region. A two-bit mode register decides what bus writes may do to the array: in read-only mode the array is frozen, in write mode single words may be stored, and in erase mode page, whole-array and user-region erase commands take effect. A command that arrives in the wrong mode is dropped and raises a sticky error flag that software clears explicitly.

The array is held in an internal register file that starts erased (every word 0xFFFFFFFF). Each accepted erase completes in a single edge, but the controller then reports itself not ready for a fixed number of cycles. Every bus write made during that window is discarded without raising the error flag. Reads are combinational from the address and are allowed at any time.

The bus has two address spaces chosen by `bus_csr`. The control space has six word offsets: 0 status, 1 mode, 2 and 3 page erase, 4 erase all, 5 erase user region. The array space holds word indices, with main words first and the user region directly after them.

Top module: `flash_wr_ctrl`

## Requirements
- R1: After reset, status (control offset 0) reads 1 (bit 0 ready = 1, bit 1 error = 0), mode (offset 1) reads 0, and every array word reads 0xFFFFFFFF.
- R2: A write to mode stores wdata[1:0] (0 read-only, 1 write, 2 erase, 3 neither), and mode reads back that value in bits 1:0 with all other bits zero. No other write changes mode.
- R3: In mode 1, a write to array index i below MAIN_PAGES*PAGE_WORDS+USER_WORDS stores the word, and it reads back on the next cycle. Array indices past the end read 0, and so do control offsets above 5.
- R4: An array write while mode is not 1 leaves the array unchanged and sets the error bit (status bit 1).
- R5: In mode 2, writing a word index below MAIN_PAGES*PAGE_WORDS to offset 2 or offset 3 sets every word of the page containing that index to 0xFFFFFFFF and leaves all other words unchanged. The index is rounded down to its page start.
- R6: In mode 2, writing a value with bit 0 set to offset 4 sets every main and user-region word to 0xFFFFFFFF.
- R7: In mode 2, writing a value with bit 0 set to offset 5 sets only the user-region words to 0xFFFFFFFF. The main words are kept.
- R8: An erase command at offset 2, 3, or 4/5 with bit 0 set is ignored and sets the error bit if mode is not 2. The same holds for a page-erase index outside the main region. A write to offset 4 or 5 with bit 0 clear does nothing.
- R9: After an accepted erase, status bit 0 reads 0 for exactly ERASE_CYCLES cycles. Any bus write made while it is 0 is ignored and does not set the error bit.
- R10: The error bit stays set until a write to offset 0 with wdata[1] = 1 clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Bus access request |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_csr | input | 1 | 1 = control space, 0 = array space |
| bus_addr | input | BUS_AW | Word offset or array word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current address (combinational) |

## Verification
The bench builds the block with 8 pages of 4 words, a 4-word user region and a 5-cycle erase window. With these values the whole array is 36 words, so the bench can check that erase-all, erase-user and page erase touch exactly the words they should. Page boundaries fall at small indices, which makes the round-down of unaligned page addresses easy to hit. The short window allows the not-ready cycles to be counted exactly and a write to be placed inside the window.

// File: rtl/flash_ctl_pkg.sv
package flash_ctl_pkg;

  localparam logic [1:0] MODE_RO = 2'd0;
  localparam logic [1:0] MODE_WR = 2'd1;
  localparam logic [1:0] MODE_ER = 2'd2;

  localparam int unsigned OFS_STATUS = 0;
  localparam int unsigned OFS_MODE   = 1;
  localparam int unsigned OFS_PG_A   = 2;
  localparam int unsigned OFS_PG_B   = 3;
  localparam int unsigned OFS_ALL    = 4;
  localparam int unsigned OFS_USER   = 5;

  typedef struct packed {
    logic wr_word;
    logic er_page;
    logic er_all;
    logic er_user;
    logic set_mode;
    logic set_err;
    logic clr_err;
  } flash_op_t;

endpackage

// File: rtl/flash_cmd_dec.sv
module flash_cmd_dec
  import flash_ctl_pkg::*;
#(
  parameter int MAIN_PAGES = 256,
  parameter int PAGE_WORDS = 4,
  parameter int USER_WORDS = 8,
  parameter int BUS_AW     = 16,
  localparam int MAIN_WORDS = MAIN_PAGES * PAGE_WORDS,
  localparam int TOTAL      = MAIN_WORDS + USER_WORDS,
  localparam int PW_LG      = $clog2(PAGE_WORDS),
  localparam int PAGE_W     = $clog2(MAIN_PAGES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic              bus_csr,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic [1:0]        mode,
  input  logic              ready,
  output flash_op_t         op,
  output logic [PAGE_W-1:0] page_idx
);

  localparam logic [BUS_AW-1:0] TOTAL_A    = BUS_AW'(TOTAL);
  localparam logic [31:0]       MAIN_LIMIT = 32'(MAIN_WORDS);

  logic accept;
  logic erase_ok;
  logic page_in_range;

  assign accept        = bus_valid & bus_write & ready;
  assign erase_ok      = (mode == MODE_ER);
  assign page_in_range = (bus_wdata < MAIN_LIMIT);
  assign page_idx      = bus_wdata[PW_LG +: PAGE_W];

  always_comb begin
    op = '0;
    if (accept && bus_csr) begin
      case (bus_addr)
        BUS_AW'(OFS_STATUS): op.clr_err  = bus_wdata[1];
        BUS_AW'(OFS_MODE):   op.set_mode = 1'b1;
        BUS_AW'(OFS_PG_A),
        BUS_AW'(OFS_PG_B): begin
          if (erase_ok && page_in_range) op.er_page = 1'b1;
          else                           op.set_err = 1'b1;
        end
        BUS_AW'(OFS_ALL): if (bus_wdata[0]) begin
          if (erase_ok) op.er_all  = 1'b1;
          else          op.set_err = 1'b1;
        end
        BUS_AW'(OFS_USER): if (bus_wdata[0]) begin
          if (erase_ok) op.er_user = 1'b1;
          else          op.set_err = 1'b1;
        end
        default: ;
      endcase
    end else if (accept && (bus_addr < TOTAL_A)) begin
      if (mode == MODE_WR) op.wr_word = 1'b1;
      else                 op.set_err = 1'b1;
    end
  end

  // R9: nothing is issued while the erase window is open
  p_quiet_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> (op == '0));

  // R3/R6: at most one array operation per cycle
  p_one_op_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({op.wr_word, op.er_page, op.er_all, op.er_user}));

endmodule

// File: rtl/flash_ctl_regs.sv
module flash_ctl_regs
  import flash_ctl_pkg::*;
#(
  parameter int ERASE_CYCLES = 8,
  localparam int CNT_W = $clog2(ERASE_CYCLES + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  flash_op_t  op,
  input  logic [1:0] wr_mode,
  output logic [1:0] mode,
  output logic       err,
  output logic       ready
);

  logic [1:0]       mode_q, mode_n;
  logic             err_q, err_n;
  logic [CNT_W-1:0] busy_q, busy_n;
  logic             erase_go;

  assign erase_go = op.er_page | op.er_all | op.er_user;

  always_comb begin
    mode_n = mode_q;
    if (op.set_mode) mode_n = wr_mode;
    err_n = err_q;
    if (op.set_err)      err_n = 1'b1;
    else if (op.clr_err) err_n = 1'b0;
    busy_n = busy_q;
    if (erase_go)                busy_n = CNT_W'(ERASE_CYCLES);
    else if (busy_q != '0)       busy_n = busy_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_RO;
      err_q  <= 1'b0;
      busy_q <= '0;
    end else begin
      mode_q <= mode_n;
      err_q  <= err_n;
      busy_q <= busy_n;
    end
  end

  assign mode  = mode_q;
  assign err   = err_q;
  assign ready = (busy_q == '0);

  p_mode_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !op.set_mode |=> $stable(mode_q));

  p_ready_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    erase_go |=> !ready);

  p_busy_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q != '0) |=> (busy_q == $past(busy_q) - CNT_W'(1)));

  p_err_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    op.set_err |=> err_q);

  p_err_clr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (op.clr_err && !op.set_err) |=> !err_q);

endmodule

// File: rtl/flash_store.sv
module flash_store
  import flash_ctl_pkg::*;
#(
  parameter int MAIN_PAGES = 256,
  parameter int PAGE_WORDS = 4,
  parameter int USER_WORDS = 8,
  parameter int BUS_AW     = 16,
  localparam int MAIN_WORDS = MAIN_PAGES * PAGE_WORDS,
  localparam int TOTAL      = MAIN_WORDS + USER_WORDS,
  localparam int IDX_W      = $clog2(TOTAL),
  localparam int PAGE_W     = $clog2(MAIN_PAGES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  flash_op_t         op,
  input  logic [PAGE_W-1:0] page_idx,
  input  logic [BUS_AW-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata
);

  localparam logic [BUS_AW-1:0] TOTAL_A = BUS_AW'(TOTAL);

  logic [31:0]      mem [TOTAL];
  logic [TOTAL-1:0] clr_vec;
  logic [TOTAL-1:0] we_vec;

  for (genvar i = 0; i < TOTAL; i++) begin : g_word
    if (i < MAIN_WORDS) begin : g_main
      assign clr_vec[i] = op.er_all |
                          (op.er_page & (page_idx == PAGE_W'(i / PAGE_WORDS)));
    end else begin : g_user
      assign clr_vec[i] = op.er_all | op.er_user;
    end
    assign we_vec[i] = op.wr_word & (addr[IDX_W-1:0] == IDX_W'(i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < TOTAL; k++) mem[k] <= '1;
    end else begin
      for (int k = 0; k < TOTAL; k++) begin
        if (clr_vec[k])      mem[k] <= '1;
        else if (we_vec[k])  mem[k] <= wdata;
      end
    end
  end

  assign rdata = (addr < TOTAL_A) ? mem[addr[IDX_W-1:0]] : 32'h0;

  p_wr_word0_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (op.wr_word && addr == '0) |=> (mem[0] == $past(wdata)));

  p_user_erase_r7: assert property (@(posedge clk) disable iff (!rst_n)
    op.er_user |=> (mem[MAIN_WORDS] == '1 && $stable(mem[0])));

  p_all_erase_r6: assert property (@(posedge clk) disable iff (!rst_n)
    op.er_all |=> (mem[0] == '1 && mem[TOTAL-1] == '1));

endmodule

// File: rtl/flash_wr_ctrl.sv
module flash_wr_ctrl
  import flash_ctl_pkg::*;
#(
  parameter int MAIN_PAGES   = 256,
  parameter int PAGE_WORDS   = 4,
  parameter int USER_WORDS   = 8,
  parameter int ERASE_CYCLES = 8,
  parameter int BUS_AW       = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic              bus_csr,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata
);

  localparam int PAGE_W = $clog2(MAIN_PAGES);

  flash_op_t         op;
  logic [PAGE_W-1:0] page_idx;
  logic [1:0]        mode;
  logic              err;
  logic              ready;
  logic [31:0]       arr_rdata;
  logic [31:0]       csr_rdata;

  flash_cmd_dec #(
    .MAIN_PAGES (MAIN_PAGES),
    .PAGE_WORDS (PAGE_WORDS),
    .USER_WORDS (USER_WORDS),
    .BUS_AW     (BUS_AW)
  ) u_dec (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_csr   (bus_csr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .mode      (mode),
    .ready     (ready),
    .op        (op),
    .page_idx  (page_idx)
  );

  flash_ctl_regs #(
    .ERASE_CYCLES (ERASE_CYCLES)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .op      (op),
    .wr_mode (bus_wdata[1:0]),
    .mode    (mode),
    .err     (err),
    .ready   (ready)
  );

  flash_store #(
    .MAIN_PAGES (MAIN_PAGES),
    .PAGE_WORDS (PAGE_WORDS),
    .USER_WORDS (USER_WORDS),
    .BUS_AW     (BUS_AW)
  ) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .op       (op),
    .page_idx (page_idx),
    .addr     (bus_addr),
    .wdata    (bus_wdata),
    .rdata    (arr_rdata)
  );

  always_comb begin
    csr_rdata = 32'h0;
    if (bus_addr == BUS_AW'(OFS_STATUS))    csr_rdata = {30'h0, err, ready};
    else if (bus_addr == BUS_AW'(OFS_MODE)) csr_rdata = {30'h0, mode};
  end

  assign bus_rdata = bus_csr ? csr_rdata : arr_rdata;

  // R4: a refused array write raises the error flag
  p_refused_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && !bus_csr && ready && mode != MODE_WR &&
     bus_addr < BUS_AW'(MAIN_PAGES * PAGE_WORDS + USER_WORDS)) |=> err);

endmodule

// File: tb/flash_wr_ctrl_bench.sv
module flash_wr_ctrl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NP  = 8;
  localparam int PW  = 4;
  localparam int UW  = 4;
  localparam int EC  = 5;
  localparam int AW  = 16;
  localparam int MW  = NP * PW;
  localparam int TW  = MW + UW;
  localparam logic [31:0] ERASED = 32'hFFFF_FFFF;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_valid = 1'b0;
  logic          bus_write = 1'b0;
  logic          bus_csr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;

  int checks = 0;
  int errors = 0;

  int unsigned mdl_mem [TW];
  int unsigned mdl_mode;
  int unsigned mdl_err;
  int          mdl_busy;

  always #(CLK_PERIOD / 2) clk = ~clk;

  flash_wr_ctrl #(
    .MAIN_PAGES (NP), .PAGE_WORDS (PW), .USER_WORDS (UW),
    .ERASE_CYCLES (EC), .BUS_AW (AW)
  ) u_flash_wr_ctrl (
    .clk (clk), .rst_n (rst_n), .bus_valid (bus_valid), .bus_write (bus_write),
    .bus_csr (bus_csr), .bus_addr (bus_addr), .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata)
  );

  function automatic logic [31:0] mdl_read(logic csr, logic [AW-1:0] a);
    if (csr) begin
      if (a == 0) return {30'h0, mdl_err[0], (mdl_busy == 0)};
      if (a == 1) return mdl_mode;
      return 32'h0;
    end
    if (int'(a) < TW) return mdl_mem[a];
    return 32'h0;
  endfunction

  // behavioural model, updated on every rising edge
  always @(posedge clk) begin
    if (rst_n) begin
      logic acc;
      acc = bus_valid && bus_write && (mdl_busy == 0);
      if (mdl_busy > 0) mdl_busy--;
      if (acc && bus_csr) begin
        case (int'(bus_addr))
          0: if (bus_wdata[1]) mdl_err = 0;
          1: mdl_mode = bus_wdata[1:0];
          2, 3: begin
            if (mdl_mode == 2 && bus_wdata < MW) begin
              int base;
              base = (int'(bus_wdata) / PW) * PW;
              for (int k = 0; k < PW; k++) mdl_mem[base + k] = ERASED;
              mdl_busy = EC;
            end else mdl_err = 1;
          end
          4: if (bus_wdata[0]) begin
            if (mdl_mode == 2) begin
              for (int k = 0; k < TW; k++) mdl_mem[k] = ERASED;
              mdl_busy = EC;
            end else mdl_err = 1;
          end
          5: if (bus_wdata[0]) begin
            if (mdl_mode == 2) begin
              for (int k = MW; k < TW; k++) mdl_mem[k] = ERASED;
              mdl_busy = EC;
            end else mdl_err = 1;
          end
          default: ;
        endcase
      end else if (acc && int'(bus_addr) < TW) begin
        if (mdl_mode == 1) mdl_mem[bus_addr] = bus_wdata;
        else               mdl_err = 1;
      end
    end
  end

  // lockstep comparison on every falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      logic [31:0] e;
      e = mdl_read(bus_csr, bus_addr);
      checks++;
      if (bus_rdata !== e) begin
        errors++;
        $display("FAIL R3 lockstep csr=%0d addr=%0d actual=%h expected=%h",
                 bus_csr, bus_addr, bus_rdata, e);
      end
    end
  end

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic wr(logic csr, int a, logic [31:0] d);
    bus_valid = 1'b1; bus_write = 1'b1; bus_csr = csr;
    bus_addr = AW'(a); bus_wdata = d;
    @(posedge clk); #1;
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(logic csr, int a, logic [31:0] exp, string tag);
    bus_valid = 1'b0; bus_write = 1'b0; bus_csr = csr; bus_addr = AW'(a);
    @(negedge clk);
    chk(tag, bus_rdata, exp);
    @(posedge clk); #1;
  endtask

  task automatic wait_ready();
    repeat (EC + 1) @(posedge clk);
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int k = 0; k < TW; k++) mdl_mem[k] = ERASED;
    mdl_mode = 0; mdl_err = 0; mdl_busy = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;

    // R1 reset state
    rd(1, 0, 32'h1, "R1 status");
    rd(1, 1, 32'h0, "R1 mode");
    rd(0, 5, ERASED, "R1 main word");
    rd(0, 33, ERASED, "R1 user word");

    // R2 mode readback
    wr(1, 1, 32'hFFFF_FFF7);
    rd(1, 1, 32'h3, "R2 mode 3");
    wr(1, 1, 32'h1);
    rd(1, 1, 32'h1, "R2 mode 1");

    // R3 writes in mode 1
    wr(0, 5, 32'h1234_5678);
    rd(0, 5, 32'h1234_5678, "R3 main write");
    wr(0, 33, 32'h0000_00A5);
    rd(0, 33, 32'h0000_00A5, "R3 user write");
    wr(0, 9, 32'h9);
    wr(0, 10, 32'hA);
    wr(0, 2, 32'h2);
    rd(0, 40, 32'h0, "R3 beyond array");
    rd(1, 7, 32'h0, "R3 unused offset");

    // R4 refused array write, R10 clear
    wr(1, 1, 32'h0);
    wr(0, 6, 32'h77);
    rd(0, 6, ERASED, "R4 array unchanged");
    rd(1, 0, 32'h3, "R4 error set");
    wr(1, 0, 32'h0);
    rd(1, 0, 32'h3, "R10 sticky error");
    wr(1, 0, 32'h2);
    rd(1, 0, 32'h1, "R10 error cleared");

    // R5 page erase via first register, unaligned index, R9 window
    wr(1, 1, 32'h2);
    wr(1, 2, 32'h6);
    bus_csr = 1'b1; bus_addr = AW'(0);
    begin
      int lows = 0;
      for (int n = 0; n < EC + 3; n++) begin
        @(negedge clk);
        if (bus_rdata[0] == 1'b0) lows++;
      end
      chk("R9 not-ready cycles", 32'(lows), 32'(EC));
    end
    @(posedge clk); #1;
    rd(0, 5, ERASED, "R5 page erased");
    rd(0, 9, 32'h9, "R5 next page kept");

    // R5 second register, R9 write during window ignored
    wr(1, 3, 32'h8);
    wr(1, 1, 32'h1);
    rd(1, 1, 32'h2, "R9 write ignored while busy");
    wait_ready();
    rd(1, 0, 32'h1, "R9 no error from busy write");
    rd(0, 9, ERASED, "R5 second register erase");
    rd(0, 2, 32'h2, "R5 other page kept");

    // R8 erase in wrong mode, out-of-range page, bit0 clear
    wr(1, 1, 32'h1);
    wr(1, 4, 32'h1);
    rd(0, 2, 32'h2, "R8 erase-all refused");
    rd(1, 0, 32'h3, "R8 error set");
    wr(1, 0, 32'h2);
    wr(1, 1, 32'h2);
    wr(1, 2, 32'd40);
    rd(1, 0, 32'h3, "R8 page out of range");
    wr(1, 0, 32'h2);
    wr(1, 4, 32'h0);
    rd(1, 0, 32'h1, "R8 bit0 clear no action");
    rd(0, 2, 32'h2, "R8 bit0 clear array kept");

    // R7 user-region erase
    wr(1, 5, 32'h1);
    wait_ready();
    rd(0, 33, ERASED, "R7 user erased");
    rd(0, 2, 32'h2, "R7 main kept");

    // R6 erase all
    wr(1, 1, 32'h1);
    wr(0, 34, 32'h55);
    wr(1, 1, 32'h2);
    wr(1, 4, 32'h1);
    wait_ready();
    rd(0, 2, ERASED, "R6 main erased");
    rd(0, 34, ERASED, "R6 user erased");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule